// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block sits between a local bus and a PCI host interface and turns each local-bus address into a PCI address. It holds a small set of programmable windows; three by default. Each window pairs a base register with a map register. The base register gives the local start address, the window size, a prefetchable flag and an enable. The map register gives the PCI address bits that replace the upper local bits, and the kind of PCI cycle to run.

Every presented address is compared against all windows in the same cycle. When several enabled windows cover the address, the window with the lowest index supplies the translation. Software can therefore widen a low-numbered window over a higher one, reprogram the hidden window (for example into a configuration aperture), and then shrink the low window again to reveal it. Translation is combinational from the programmed registers and the address. Register writes take effect at the next clock edge.

Top module: `lbWinXlate`

## Requirements
- R1: After reset every window is disabled, every register reads as zero and `hit` is 0 for any address.
- R2: `regAddr` selects the window index in bits 2:1 and the register in bit 0 (0 = base, 1 = map). A read returns the last value written: the full 32 bits for a base, and the 16 map bits zero-extended. Window indices at or above the window count ignore writes and read as zero.
- R3: An enabled window matches when `lbAddr` and the base register agree in every bit at or above position S. Here S = 20 + size code, and the size code is base bits 7:4: code 4 is 16 MB, code 8 is 256 MB, code 9 is 512 MB. S is capped at 32, so codes 12 and above cover the whole space.
- R4: When several enabled windows match, the one with the lowest index wins.
- R5: On a hit, `pciAddr` bits below S come from `lbAddr`. Bits at or above S come from `{map[15:4], 20'b0}`.
- R6: On a hit, `cycType` equals map bits 3:1 of the winning window (011 = memory, 101 = configuration).
- R7: On a hit with cycle type 101, map bit 0 = 0 forces `pciAddr[1:0]` to 00. Map bit 0 = 1 passes `lbAddr[1:0]` through. For other cycle types the low bits always pass through.
- R8: On a hit, `prefetch` equals base bit 2 of the winning window.
- R9: With no matching window, `hit` = 0, `pciAddr` = `lbAddr`, `cycType` = 000 and `prefetch` = 0.
- R10: A window whose enable bit (base bit 0) is 0 never matches. An overlapping enabled window of higher index then takes the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select {window index, base/map} |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the register selected by regAddr |
| lbAddr | input | 32 | Local-bus address to translate |
| pciAddr | output | 32 | Translated PCI address |
| cycType | output | 3 | PCI cycle type of the winning window |
| prefetch | output | 1 | Winning window is prefetchable |
| hit | output | 1 | Some enabled window matched |

## Verification
A corrupted base or map register shows up on `regRdData` one clock after the write. It also shows up on `pciAddr`, `hit` and `cycType` as soon as an address inside or near the affected window is presented, since translation has no pipeline stage. A wrong priority or size decode only shows for addresses in overlap zones or at window edges. The sweeps therefore walk every 16 MB step of the address space with low-bit patterns that exercise both pass-through and forced address bits. A stuck enable or a missed reset shows as a hit where a miss was due, immediately after reset or after a window is disabled.

// File: rtl/lbWinPkg.sv
package lbWinPkg;
  localparam int WIN_IDX_W = 2;
  localparam int MAX_WIN   = 1 << WIN_IDX_W;
  localparam int REG_SEL_W = WIN_IDX_W + 1;

  localparam logic [2:0] CYC_NONE = 3'b000;
  localparam logic [2:0] CYC_MEM  = 3'b011;
  localparam logic [2:0] CYC_CFG  = 3'b101;

  // strobes from register control to the window datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 isMap;
    logic [WIN_IDX_W-1:0] win;
    logic                 inRange;
  } winStb_t;
endpackage

// File: rtl/lbWinCtrl.sv
module lbWinCtrl
  import lbWinPkg::*;
#(
  parameter int NUM_WIN = 3
) (
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regAddr,
  output winStb_t              stb
);
  localparam logic [WIN_IDX_W:0] WIN_LIMIT = (WIN_IDX_W+1)'(NUM_WIN);

  logic [WIN_IDX_W-1:0] winIdx;
  logic                 idxOk;

  assign winIdx = regAddr[REG_SEL_W-1:1];
  assign idxOk  = ({1'b0, winIdx} < WIN_LIMIT);

  always_comb begin
    stb.wrEn    = regWrEn && idxOk;
    stb.isMap   = regAddr[0];
    stb.win     = winIdx;
    stb.inRange = idxOk;
  end
endmodule

// File: rtl/lbWinPath.sv
module lbWinPath
  import lbWinPkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int ADDR_W  = 32,
  parameter int MIN_SH  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStb_t           stb,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] rdData,
  input  logic [ADDR_W-1:0] lbAddr,
  output logic [ADDR_W-1:0] pciAddr,
  output logic [2:0]        cycType,
  output logic              prefetch,
  output logic              hit
);
  localparam int MAP_UP = ADDR_W - MIN_SH;
  localparam int MAP_W  = MAP_UP + 4;

  logic [NUM_WIN-1:0][ADDR_W-1:0] baseQ;
  logic [NUM_WIN-1:0][MAP_W-1:0]  mapQ;
  logic [NUM_WIN-1:0][ADDR_W-1:0] xlAddr;
  logic [NUM_WIN-1:0]             winMatch;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] baseR;
    logic [MAP_W-1:0]  mapR;
    logic [ADDR_W-1:0] lowMask;
    logic [ADDR_W-1:0] xl;
    logic              selW;

    assign selW = (stb.win == WIN_IDX_W'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseR <= '0;
        mapR  <= '0;
      end else if (stb.wrEn && selW) begin
        if (stb.isMap) mapR  <= wrData[MAP_W-1:0];
        else           baseR <= wrData;
      end
    end

    // bits below the window size pass through
    always_comb begin
      int shAmt;
      shAmt = MIN_SH + int'(baseR[7:4]);
      if (shAmt > ADDR_W) shAmt = ADDR_W;
      for (int b = 0; b < ADDR_W; b++) lowMask[b] = (b < shAmt);
    end

    always_comb begin
      xl = (lbAddr & lowMask) | ({mapR[MAP_W-1:4], {MIN_SH{1'b0}}} & ~lowMask);
      if (mapR[3:1] == CYC_CFG && !mapR[0]) xl[1:0] = 2'b00;
    end

    assign winMatch[w] = baseR[0] && (((lbAddr ^ baseR) & ~lowMask) == '0);
    assign xlAddr[w]   = xl;
    assign baseQ[w]    = baseR;
    assign mapQ[w]     = mapR;
  end

  // lowest index wins: walk downward so the last assignment is the lowest
  always_comb begin
    hit      = 1'b0;
    pciAddr  = lbAddr;
    cycType  = CYC_NONE;
    prefetch = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (winMatch[w]) begin
        hit      = 1'b1;
        pciAddr  = xlAddr[w];
        cycType  = mapQ[w][3:1];
        prefetch = baseQ[w][2];
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (stb.inRange && stb.win == WIN_IDX_W'(w))
        rdData = stb.isMap ? {{(ADDR_W-MAP_W){1'b0}}, mapQ[w]} : baseQ[w];
    end
  end
endmodule

// File: rtl/lbWinXlate.sv
module lbWinXlate
  import lbWinPkg::*;
#(
  parameter int NUM_WIN = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [31:0]          lbAddr,
  output logic [31:0]          pciAddr,
  output logic [2:0]           cycType,
  output logic                 prefetch,
  output logic                 hit
);
  localparam int ADDR_W = 32;
  localparam int MIN_SH = 20;

  winStb_t stb;

  lbWinCtrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  lbWinPath #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .MIN_SH(MIN_SH)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .lbAddr   (lbAddr),
    .pciAddr  (pciAddr),
    .cycType  (cycType),
    .prefetch (prefetch),
    .hit      (hit)
  );
endmodule

// File: rtl/lbWinXlateChk.sv
module lbWinXlateChk
  import lbWinPkg::*;
#(
  parameter int NUM_WIN = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [REG_SEL_W-1:0] regAddr,
  input logic [31:0]          regWrData,
  input logic [31:0]          regRdData,
  input logic [31:0]          lbAddr,
  input logic [31:0]          pciAddr,
  input logic [2:0]           cycType,
  input logic                 prefetch,
  input logic                 hit
);
  localparam logic [WIN_IDX_W:0] WIN_LIMIT = (WIN_IDX_W+1)'(NUM_WIN);

  // R1: first cycle out of reset nothing is enabled
  p_reset_miss_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !hit);

  // R2: a completed write reads back on the following cycle
  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn) && !regWrEn && regAddr == $past(regAddr) &&
     ({1'b0, regAddr[REG_SEL_W-1:1]} < WIN_LIMIT))
    |-> regRdData == (regAddr[0] ? {16'b0, $past(regWrData[15:0])} : $past(regWrData)));

  // R5: the smallest window still passes the low megabyte through
  p_low_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cycType != CYC_CFG) |-> pciAddr[19:0] == lbAddr[19:0]);

  // R7: configuration cycles keep bits 19:2 of the local address
  p_cfg_mid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hit && cycType == CYC_CFG) |-> pciAddr[19:2] == lbAddr[19:2]);

  // R8: prefetch only accompanies a hit
  p_pf_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    prefetch |-> hit);

  // R9: misses leave the address untouched
  p_miss_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (pciAddr == lbAddr && cycType == CYC_NONE && !prefetch));
endmodule

bind lbWinXlate lbWinXlateChk #(.NUM_WIN(NUM_WIN)) u_chk (.*);

// File: tb/lbWinXlate_tb.sv
module lbWinXlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] lbAddr = '0;
  logic [31:0] pciAddr;
  logic [2:0]  cycType;
  logic        prefetch;
  logic        hit;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] shBase [3];
  logic [15:0] shMap  [3];

  always #2.5 clk = ~clk;

  lbWinXlate u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lbAddr(lbAddr),
    .pciAddr(pciAddr), .cycType(cycType), .prefetch(prefetch), .hit(hit)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a[2:1] < 2'd3) begin
      if (a[0]) shMap[a[2:1]] = d[15:0];
      else      shBase[a[2:1]] = d;
    end
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData === exp, req, regRdData, exp);
  endtask

  task automatic model(input logic [31:0] a, output bit eHit, output logic [31:0] ePci,
                       output logic [2:0] eCyc, output bit ePf);
    eHit = 0; ePci = a; eCyc = 3'b000; ePf = 0;
    for (int w = 0; w < 3; w++) begin
      if (!eHit && shBase[w][0]) begin
        int sh;
        logic [32:0] one;
        logic [31:0] lowM;
        sh = 20 + int'(shBase[w][7:4]);
        if (sh > 32) sh = 32;
        one = 33'd1 << sh;
        lowM = 32'(one - 33'd1);
        if (((a ^ shBase[w]) & ~lowM) == 32'd0) begin
          eHit = 1;
          ePci = (a & lowM) | ({shMap[w][15:4], 20'd0} & ~lowM);
          if (shMap[w][3:1] == 3'b101 && !shMap[w][0]) ePci[1:0] = 2'b00;
          eCyc = shMap[w][3:1];
          ePf  = shBase[w][2];
        end
      end
    end
  endtask

  task automatic sweep(input string hitReq);
    logic [23:0] pats [4] = '{24'h000000, 24'hFFFFFF, 24'hA5A5A7, 24'h3C0F01};
    for (int hi = 0; hi < 256; hi++) begin
      for (int k = 0; k < 4; k++) begin
        bit eHit, ePf;
        logic [31:0] ePci;
        logic [2:0] eCyc;
        logic [31:0] a;
        a = {hi[7:0], pats[k]};
        model(a, eHit, ePci, eCyc, ePf);
        @(negedge clk);
        lbAddr = a;
        #1;
        chk(hit === eHit, hitReq, {31'd0, hit}, {31'd0, eHit});
        chk(pciAddr === ePci, eHit ? "R5" : "R9", pciAddr, ePci);
        chk(cycType === eCyc, eHit ? "R6" : "R9", {29'd0, cycType}, {29'd0, eCyc});
        chk(prefetch === ePf, eHit ? "R8" : "R9", {31'd0, prefetch}, {31'd0, ePf});
        if (eHit && eCyc == 3'b101)
          chk(pciAddr[1:0] === ePci[1:0], "R7", {30'd0, pciAddr[1:0]}, {30'd0, ePci[1:0]});
      end
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < 3; w++) begin shBase[w] = '0; shMap[w] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rdChk(3'(a), 32'd0, "R1");
    sweep("R1");

    // R3: three disjoint windows, memory and other cycle types
    wrReg(3'd0, 32'h4000_0081); wrReg(3'd1, 32'h0000_0006);
    wrReg(3'd2, 32'h5000_0085); wrReg(3'd3, 32'h0000_1006);
    wrReg(3'd4, 32'h6000_0041); wrReg(3'd5, 32'h0000_0A54);
    for (int a = 0; a < 6; a++)
      rdChk(3'(a), a[0] ? {16'd0, shMap[a/2]} : shBase[a/2], "R2");
    sweep("R3");

    // R4: window 0 widened to 512 MB hides window 1, which becomes a config aperture
    wrReg(3'd0, 32'h4000_0091);
    wrReg(3'd2, 32'h6800_0041); wrReg(3'd3, 32'h0000_000A);
    sweep("R4");
    // R7: pass host A1:A0 through
    wrReg(3'd3, 32'h0000_000B);
    sweep("R7");
    // R4: window 1 placed inside window 0 stays hidden
    wrReg(3'd2, 32'h5000_0045);
    sweep("R4");

    // R10: disabling window 0 reveals window 1
    wrReg(3'd0, 32'h4000_0094);
    sweep("R10");

    // R2: out-of-range window index ignored
    wrReg(3'd6, 32'hFFFF_FFFF); wrReg(3'd7, 32'hFFFF_FFFF);
    rdChk(3'd6, 32'd0, "R2"); rdChk(3'd7, 32'd0, "R2");
    for (int a = 0; a < 6; a++)
      rdChk(3'(a), a[0] ? {16'd0, shMap[a/2]} : shBase[a/2], "R2");
    sweep("R2");

    // R3: size code at or above 12 covers everything
    wrReg(3'd0, 32'h4000_0081);
    wrReg(3'd4, 32'h1230_00F1); wrReg(3'd5, 32'h0000_ABC6);
    sweep("R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule